// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with Result Pair Registers

This block multiplies or divides two 32-bit integers, signed or unsigned, over many clock cycles. It uses one shifting register pair and a single adder/subtractor for both jobs. A one-cycle start pulse hands over an opcode and two operands. The unit then holds busy for a fixed number of cycles, pulses done once, and leaves its result in two architectural registers, called here the upper word (HI) and the lower word (LO). Both registers can be read continuously.

A multiply leaves the full double-width product split across HI (upper half) and LO (lower half). A divide leaves the remainder in HI and the quotient in LO. Signed operations run on operand magnitudes, and the signs are corrected in a final cycle. Nothing traps: overflow and division by zero produce defined values.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy_o and done_o are low and hi_o and lo_o are both zero.
- R2: Opcode 2'b01 (unsigned multiply) leaves the 64-bit unsigned product of a_i and b_i with its upper 32 bits in hi_o and its lower 32 bits in lo_o.
- R3: Opcode 2'b00 (signed multiply) leaves the 64-bit two's-complement product of a_i and b_i split in the same way, upper half in hi_o.
- R4: Opcode 2'b11 (unsigned divide) leaves the quotient a_i / b_i in lo_o and the remainder in hi_o.
- R5: Opcode 2'b10 (signed divide) leaves in lo_o the quotient truncated toward zero, negated when the operand signs differ. The remainder goes to hi_o with the sign of the dividend. The case -2^31 / -1 gives quotient 32'h8000_0000 and remainder 0.
- R6: A divide by zero completes normally and sets hi_o equal to the dividend. For the unsigned divide, lo_o is all ones. For the signed divide, lo_o is all ones when the dividend is non-negative and 1 when it is negative.
- R7: A start accepted while idle holds busy_o high for exactly 34 cycles: one setup cycle, 32 iteration cycles and one finish cycle. done_o is high for exactly one cycle, the first cycle after busy_o falls, and the new result is visible on hi_o and lo_o in that same cycle.
- R8: A start pulse that arrives while busy_o is high is ignored. The running operation completes with its own operands, and no second done_o pulse follows.
- R9: hi_o and lo_o change only in a cycle in which done_o is high. Between operations they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper product half or remainder |
| lo_o | output | 32 | Lower product half or quotient |

## Verification
Each of the four opcodes is driven with operands that have both signs, with zero, with ones, with all-ones and with the most negative value. Mixed-sign pairs reveal a missing or misplaced sign correction. Products that overflow 32 bits reveal a dropped carry or a wrong split between HI and LO. A divisor larger than the dividend, and divisions by zero with dividends of either sign, separate a correct restoring step from one that mishandles the trial subtraction. A start issued in the middle of a run, followed by a long idle stretch, shows whether the unit leaks extra work or disturbs the result registers.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      OP_MUL  = 2'b00,
      OP_MULU = 2'b01,
      OP_DIV  = 2'b10,
      OP_DIVU = 2'b11
   } md_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_RUN   = 2'd2,
      ST_FIN   = 2'd3
   } md_state_e;
endpackage

// File: rtl/muldiv_mag.sv
// Converts an operand to magnitude plus sign flag.
module muldiv_mag #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [W-1:0] val_i,
   input  logic         is_signed_i,
   output logic [W-1:0] mag_o,
   output logic         neg_o
);
   generate
      if (SIGNED_EN) begin : g_signed
         always_comb begin
            neg_o = is_signed_i & val_i[W-1];
            mag_o = neg_o ? (~val_i + W'(1)) : val_i;
         end
      end else begin : g_unsigned
         logic unused_sig;
         always_comb begin
            unused_sig = is_signed_i;
            neg_o      = 1'b0;
            mag_o      = val_i;
         end
      end
   endgenerate
endmodule

// File: rtl/muldiv_step.sv
// One iteration of the shared datapath: shift-add multiply or restoring divide.
module muldiv_step #(
   parameter int W = 32
) (
   input  logic         is_div_i,
   input  logic [W:0]   hi_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] opnd_i,
   output logic [W:0]   hi_o,
   output logic [W-1:0] lo_o
);
   localparam int AW = W + 2;

   logic [W:0]    shl;
   logic [AW-1:0] x_op, y_op, sum;
   logic [W:0]    acc;

   always_comb begin
      shl  = {hi_i[W-1:0], lo_i[W-1]};
      x_op = is_div_i ? {1'b0, shl} : {1'b0, hi_i};
      y_op = is_div_i ? ~{2'b00, opnd_i} : {2'b00, opnd_i};
      sum  = x_op + y_op + AW'(is_div_i);
      acc  = lo_i[0] ? sum[W:0] : hi_i;
      if (is_div_i) begin
         // negative trial keeps the shifted remainder (restore), bit 0
         hi_o = sum[AW-1] ? shl : sum[W:0];
         lo_o = {lo_i[W-2:0], ~sum[AW-1]};
      end else begin
         hi_o = {1'b0, acc[W:1]};
         lo_o = {acc[0], lo_i[W-1:1]};
      end
   end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);
   import muldiv_pkg::*;

   localparam int CW   = $clog2(W);
   localparam int LW   = $clog2(W + 3) + 1;
   localparam int BUSY = W + 2;

   generate
      if (W < 4) begin : g_bad_width
         $error("muldiv_unit: W must be at least 4");
      end
   endgenerate

   md_state_e     state_q;
   md_op_e        op_q;
   logic [W-1:0]  a_q, b_q, opnd_q, lo_w, hi_q, lo_q;
   logic [W:0]    hi_w;
   logic [CW-1:0] cnt_q;
   logic          neg_q, neg_r_q, done_q;

   logic [W-1:0]  a_mag, b_mag, lo_n;
   logic [W:0]    hi_n;
   logic          a_neg, b_neg, is_div, is_sgn;
   logic [2*W-1:0] prod, prod_fix;

   assign is_div = op_q[1];
   assign is_sgn = ~op_q[0];

   muldiv_mag #(.W(W), .SIGNED_EN(SIGNED_EN)) u_mag_a (
      .val_i(a_q), .is_signed_i(is_sgn), .mag_o(a_mag), .neg_o(a_neg));
   muldiv_mag #(.W(W), .SIGNED_EN(SIGNED_EN)) u_mag_b (
      .val_i(b_q), .is_signed_i(is_sgn), .mag_o(b_mag), .neg_o(b_neg));

   muldiv_step #(.W(W)) u_step (
      .is_div_i(is_div), .hi_i(hi_w), .lo_i(lo_w), .opnd_i(opnd_q),
      .hi_o(hi_n), .lo_o(lo_n));

   always_comb begin
      prod     = {hi_w[W-1:0], lo_w};
      prod_fix = neg_q ? (~prod + (2*W)'(1)) : prod;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_MUL;
         a_q     <= '0;
         b_q     <= '0;
         opnd_q  <= '0;
         hi_w    <= '0;
         lo_w    <= '0;
         cnt_q   <= '0;
         neg_q   <= 1'b0;
         neg_r_q <= 1'b0;
         hi_q    <= '0;
         lo_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               op_q    <= md_op_e'(op_i);
               a_q     <= a_i;
               b_q     <= b_i;
               state_q <= ST_SETUP;
            end
            ST_SETUP: begin
               hi_w    <= '0;
               lo_w    <= is_div ? a_mag : b_mag;
               opnd_q  <= is_div ? b_mag : a_mag;
               neg_q   <= a_neg ^ b_neg;
               neg_r_q <= a_neg;
               cnt_q   <= '0;
               state_q <= ST_RUN;
            end
            ST_RUN: begin
               hi_w  <= hi_n;
               lo_w  <= lo_n;
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(W - 1)) state_q <= ST_FIN;
            end
            ST_FIN: begin
               if (is_div) begin
                  lo_q <= neg_q   ? (~lo_w + W'(1)) : lo_w;
                  hi_q <= neg_r_q ? (~hi_w[W-1:0] + W'(1)) : hi_w[W-1:0];
               end else begin
                  hi_q <= prod_fix[2*W-1:W];
                  lo_q <= prod_fix[W-1:0];
               end
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign hi_o   = hi_q;
   assign lo_o   = lo_q;

   // busy-length monitor for the timing check
   logic [LW-1:0] busy_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_len_q <= '0;
      else if (busy_o) busy_len_q <= busy_len_q + LW'(1);
      else             busy_len_q <= '0;
   end

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len_q == LW'(BUSY)));
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R8
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(op_q) && $stable(a_q) && $stable(b_q)));
   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(hi_o) && $stable(lo_o)) |-> done_o);
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [31:0] a_i = '0, b_i = '0;
   logic        busy_o, done_o;
   logic [31:0] hi_o, lo_o;

   int n_chk = 0, n_fail = 0, busy_cnt = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];
   bit          finished = 0;

   muldiv_unit u_muldiv_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
      .hi_o(hi_o), .lo_o(lo_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [1:0] op,
                                         input logic [31:0] a, b);
      longint sa, sb, q, r;
      logic [63:0] p;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (op)
         2'b00: begin p = 64'(sa * sb); return p; end
         2'b01: begin p = {32'b0, a} * {32'b0, b}; return p; end
         2'b10: begin
            if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
            q = sa / sb; r = sa % sb;
            return {r[31:0], q[31:0]};
         end
         default: begin
            if (b == 0) return {a, 32'hFFFF_FFFF};
            return {a % b, a / b};
         end
      endcase
   endfunction

   task automatic issue(input logic [1:0] op, input logic [31:0] a, b);
      op_i = op; a_i = a; b_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_op(input logic [1:0] op, input logic [31:0] a, b,
                         input string tag);
      while (busy_o) @(negedge clk);
      exp_q.push_back(model(op, a, b));
      tag_q.push_back(tag);
      issue(op, a, b);
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_o) begin
            check(busy_cnt == 34, "R7 busy length", 64'(busy_cnt), 64'd34);
            check(!busy_o, "R7 done while idle", 64'(busy_o), 64'd0);
            busy_cnt = 0;
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected done", {hi_o, lo_o}, 64'd0);
            end else begin
               logic [63:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({hi_o, lo_o} == e, t, {hi_o, lo_o}, e);
            end
         end
         if (busy_o) busy_cnt++;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy_o && !done_o, "R1 flags", {62'b0, busy_o, done_o}, 64'd0);
      check({hi_o, lo_o} == 64'd0, "R1 regs", {hi_o, lo_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(2'b01, 32'd7, 32'd6, "R2 small");
      run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 max");
      run_op(2'b01, 32'h1234_5678, 32'h0, "R2 zero");
      run_op(2'b00, 32'hFFFF_FFFB, 32'd4, "R3 neg*pos");
      run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R3 minmin");
      run_op(2'b00, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R3 -1*max");
      run_op(2'b11, 32'd74, 32'd8, "R4 basic");
      run_op(2'b11, 32'd5, 32'hFFFF_FFF0, "R4 divisor>dividend");
      run_op(2'b11, 32'hFFFF_FFFF, 32'd1, "R4 by one");
      run_op(2'b10, 32'hFFFF_FFF9, 32'd2, "R5 neg/pos");
      run_op(2'b10, 32'd7, 32'hFFFF_FFFE, "R5 pos/neg");
      run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5 neg/neg");
      run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R5 min/-1");
      run_op(2'b11, 32'hDEAD_BEEF, 32'd0, "R6 unsigned");
      run_op(2'b10, 32'd1234, 32'd0, "R6 signed pos");
      run_op(2'b10, 32'hFFFF_FF00, 32'd0, "R6 signed neg");

      // R8: second start during a run is dropped
      exp_q.push_back(model(2'b01, 32'd1000, 32'd3));
      tag_q.push_back("R8 first op result");
      issue(2'b01, 32'd1000, 32'd3);
      repeat (5) @(negedge clk);
      issue(2'b10, 32'd9, 32'd2);
      while (exp_q.size() > 0) @(negedge clk);
      // R9: result holds during an idle stretch, no extra done appears
      repeat (45) @(negedge clk);
      check(!busy_o, "R8 no restart", 64'(busy_o), 64'd0);
      check({hi_o, lo_o} == 64'd3000, "R9 hold", {hi_o, lo_o}, 64'd3000);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule